// File: doc/BRIEF.md
# PCI Base Address Register Bank

This block holds the base address registers of a PCI function's configuration header: six 32-bit slots and an expansion ROM slot. System software programs each slot through a configuration write port that honours byte enables. A configuration read port returns the register contents. The address bits below a slot's size boundary always read as zero, so writing all ones and reading back reveals how much space the slot claims. The attribute bits in the low nibble tell software whether the slot is memory or I/O, whether it is a 32-bit or 64-bit memory slot, and whether it is prefetchable.

A decode port takes a 64-bit bus address and a flag that marks I/O transactions. It reports which slot claims the address, gated by the memory-space and I/O-space enable bits of the command register, which come in as inputs. Each slot's size, type, prefetch flag, presence and hardwiring are fixed at compile time. A hardwired slot returns a parameter word, low nibble included, and ignores software. Two adjacent slots (1:0 or 2:1) can be joined into a single 64-bit memory slot, with the higher-numbered slot holding the upper address word. At least one slot must be present, and the present slots must form an unbroken run starting at slot 0. Elaboration stops with an error for any other setting.

Top module: `bar_bank`

## Requirements
- R1: On reset every writable slot clears its address bits to zero and reads back only its fixed attribute bits. A hardwired slot keeps its parameter word.
- R2: On a writable slot, the address bits below the slot's size boundary read as zero and those at or above it take written data. Writing all ones and reading back therefore returns the size mask together with the attribute bits.
- R3: The low attribute bits are read-only.
  - Bit 0 reads 1 for an I/O slot and 0 for a memory slot.
  - On a memory slot, bits 2:1 read 00 for 32-bit and 10 for the lower half of a 64-bit pair.
  - Bit 3 reads 1 when the slot is prefetchable.
- R4: A hardwired slot always reads its full parameter word, including the low four bits exactly as given, and configuration writes leave it unchanged.
- R5: A configuration write changes only the byte lanes whose enable bit is set (cfg_be[n] covers bits 8n+7:8n). With no lanes enabled, the write changes nothing.
- R6: In a 64-bit pair, the upper slot stores all 32 bits of the upper address word. The pair decodes only when dec_addr[63:32] equals that word. A 32-bit slot decodes only when dec_addr[63:32] is zero. The upper slot never reports a hit of its own.
- R7: A memory slot or the ROM slot claims only transactions with dec_io low, and only while mem_en is high. The hit is reported on hit_vec bit k for slot k, with bit 6 for the ROM, and hit_any is high whenever any bit is set.
- R8: An I/O slot claims only transactions with dec_io high, and only while io_en is high.
- R9: The ROM slot decodes only while its bit 0 (enable, writable) is set. Its bits 10:1 always read zero.
- R10: A slot that is not present reads zero, ignores writes and never hits. cfg_sel value 7 selects no slot and reads zero. Selects 0 to 5 address slots 0 to 5, and 6 addresses the ROM slot.
- R11: When several slots match, only the lowest-numbered one is reported.
- R12: Decoding is combinational on the current register contents. A configuration write in the same cycle as a decode affects the decode only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Slot select for read and write (0-5 slots, 6 ROM, 7 none) |
| cfg_be | input | 4 | Byte lane enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected slot |
| mem_en | input | 1 | Command register memory-space enable |
| io_en | input | 1 | Command register I/O-space enable |
| dec_addr | input | 64 | Bus address to decode |
| dec_io | input | 1 | High when the transaction is an I/O access |
| hit_vec | output | 7 | One-hot claiming slot (bit 6 ROM), zero when unclaimed |
| hit_any | output | 1 | High when some slot claims the address |

## Verification
A configuration write and an address decode can fall in the same cycle. One can move a slot's base while the other is checking the old window. The bench drives a base change to slot 0 together with an address inside the old window, and checks that the hit is still reported before the clock edge. After the edge it checks that the old address misses and an address in the new window hits. A second overlap is provoked by placing slot 0 over the ROM window, which shows that the lowest-numbered slot wins. Moving slot 0 away again shows that the ROM becomes visible.

// File: rtl/bar_bank_pkg.sv
package bar_bank_pkg;

    localparam int NUM_BARS  = 6;
    localparam int NUM_SLOTS = NUM_BARS + 1;
    localparam int ROM_SLOT  = NUM_BARS;
    localparam int SEL_W     = 3;

    typedef logic [31:0] word_t;
    typedef logic [SEL_W-1:0] sel_t;

    // Address bits at or above the size boundary.
    function automatic word_t size_mask(input int unsigned lg);
        return 32'hFFFF_FFFF << lg;
    endfunction

    // Expand byte lane enables into a bit mask.
    function automatic word_t lane_mask(input logic [3:0] be);
        return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    endfunction

    // Fixed low nibble of a slot: I/O flag, width code, prefetch flag.
    function automatic word_t attr_bits(input bit is_io, input bit pref, input bit wide);
        if (is_io)
            return 32'h0000_0001;
        return {28'h0, pref, wide, 1'b0, 1'b0};
    endfunction

endpackage

// File: rtl/bar_slot.sv
module bar_slot
    import bar_bank_pkg::*;
#(
    parameter bit    HARDWIRED = 1'b0,
    parameter word_t HW_VALUE  = 32'h0,
    parameter word_t WMASK     = 32'h0,
    parameter word_t FIXED     = 32'h0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  logic [3:0] be,
    input  word_t wdata,
    output word_t value
);

    word_t q;
    word_t upd_mask;

    assign upd_mask = lane_mask(be) & WMASK;

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr_en && !HARDWIRED)
            q <= (q & ~upd_mask) | (wdata & upd_mask);
    end

    always_comb begin
        if (HARDWIRED)
            value = HW_VALUE;
        else
            value = (q & WMASK) | FIXED;
    end

endmodule

// File: rtl/bar_hit_decode.sv
module bar_hit_decode
    import bar_bank_pkg::*;
#(
    parameter bit [NUM_BARS-1:0]      BAR_EN    = 6'b000001,
    parameter bit [NUM_BARS-1:0]      BAR_IO    = 6'b000000,
    parameter bit [NUM_BARS-1:0][5:0] BAR_SIZE  = {NUM_BARS{6'd20}},
    parameter int                     WIDE_MODE = 0,
    parameter bit                     ROM_EN    = 1'b0,
    parameter int                     ROM_SIZE  = 16
) (
    input  word_t [NUM_SLOTS-1:0] vals,
    input  logic [63:0]           addr,
    input  logic                  is_io,
    input  logic                  mem_en,
    input  logic                  io_en,
    output logic [NUM_SLOTS-1:0]  hit_vec
);

    logic [NUM_SLOTS-1:0] raw;
    logic                 hi_zero;

    assign hi_zero = (addr[63:32] == 32'h0);

    for (genvar k = 0; k < NUM_BARS; k++) begin : g_bar
        localparam bit    UPPER = (WIDE_MODE != 0) && (k == WIDE_MODE);
        localparam bit    LOWER = (WIDE_MODE != 0) && (k == WIDE_MODE - 1);
        localparam int    HI    = (k < NUM_BARS - 1) ? k + 1 : k;
        localparam bit    LIVE  = BAR_EN[k] && !UPPER;
        localparam word_t AMASK = size_mask(BAR_SIZE[k]);

        logic hi_ok, lo_ok, kind_ok;

        assign hi_ok   = LOWER ? (addr[63:32] == vals[HI]) : hi_zero;
        assign lo_ok   = ((addr[31:0] ^ vals[k]) & AMASK) == 32'h0;
        assign kind_ok = BAR_IO[k] ? (is_io && io_en) : (!is_io && mem_en);
        assign raw[k]  = LIVE && hi_ok && lo_ok && kind_ok;
    end

    localparam word_t ROM_MASK = size_mask(ROM_SIZE);

    assign raw[ROM_SLOT] = ROM_EN && vals[ROM_SLOT][0] && !is_io && mem_en && hi_zero
                         && (((addr[31:0] ^ vals[ROM_SLOT]) & ROM_MASK) == 32'h0);

    // Keep only the lowest-numbered claimant.
    assign hit_vec = raw & (~raw + 1'b1);

endmodule

// File: rtl/bar_bank.sv
module bar_bank
    import bar_bank_pkg::*;
#(
    parameter bit [NUM_BARS-1:0]       BAR_EN     = 6'b000001,
    parameter bit [NUM_BARS-1:0]       BAR_IO     = 6'b000000,
    parameter bit [NUM_BARS-1:0]       BAR_PREF   = 6'b000000,
    parameter bit [NUM_BARS-1:0][5:0]  BAR_SIZE   = {NUM_BARS{6'd20}},
    parameter bit [NUM_BARS-1:0]       BAR_HW     = 6'b000000,
    parameter bit [NUM_BARS-1:0][31:0] BAR_HW_VAL = '0,
    parameter int                      WIDE_MODE  = 0,
    parameter bit                      ROM_EN     = 1'b0,
    parameter int                      ROM_SIZE   = 16,
    parameter bit                      ROM_HW     = 1'b0,
    parameter bit [31:0]               ROM_HW_VAL = 32'h0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [2:0]  cfg_sel,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        mem_en,
    input  logic        io_en,
    input  logic [63:0] dec_addr,
    input  logic        dec_io,
    output logic [6:0]  hit_vec,
    output logic        hit_any
);

    // Present slots must be a non-empty run from slot 0; a pair must be two present memory slots.
    localparam bit RUN_OK  = (BAR_EN != '0) && ((BAR_EN & (BAR_EN + 1'b1)) == '0);
    localparam bit PAIR_OK = (WIDE_MODE == 0)
                          || ((WIDE_MODE == 1 || WIDE_MODE == 2)
                              && BAR_EN[WIDE_MODE] && BAR_EN[WIDE_MODE-1]
                              && !BAR_IO[WIDE_MODE] && !BAR_IO[WIDE_MODE-1]);
    localparam bit ROM_OK  = (ROM_SIZE >= 11) && (ROM_SIZE <= 31);

    if (!(RUN_OK && PAIR_OK && ROM_OK)) begin : g_bad_cfg
        $error("bar_bank: illegal slot configuration");
    end

    word_t [NUM_SLOTS-1:0] rd_val;
    word_t [7:0]           rd_all;

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
        localparam bit    IS_ROM = (k == ROM_SLOT);
        localparam int    BI     = IS_ROM ? 0 : k;
        localparam bit    UPPER  = !IS_ROM && (WIDE_MODE != 0) && (k == WIDE_MODE);
        localparam bit    LOWER  = !IS_ROM && (WIDE_MODE != 0) && (k == WIDE_MODE - 1);
        localparam bit    EN     = IS_ROM ? ROM_EN : BAR_EN[BI];
        localparam bit    HARD   = !EN || (IS_ROM ? ROM_HW : BAR_HW[BI]);
        localparam word_t HVAL   = !EN ? 32'h0 : (IS_ROM ? ROM_HW_VAL : BAR_HW_VAL[BI]);
        localparam word_t WMASK  = IS_ROM ? (size_mask(ROM_SIZE) | 32'h1)
                                 : UPPER ? 32'hFFFF_FFFF
                                 : size_mask(BAR_SIZE[BI]);
        localparam word_t FIXED  = (IS_ROM || UPPER) ? 32'h0
                                 : attr_bits(BAR_IO[BI], BAR_PREF[BI], LOWER);

        bar_slot #(
            .HARDWIRED (HARD),
            .HW_VALUE  (HVAL),
            .WMASK     (WMASK),
            .FIXED     (FIXED)
        ) u_slot (
            .clk   (clk),
            .rst   (rst),
            .wr_en (cfg_wr && (cfg_sel == SEL_W'(k))),
            .be    (cfg_be),
            .wdata (cfg_wdata),
            .value (rd_val[k])
        );
    end

    assign rd_all    = {32'h0, rd_val};
    assign cfg_rdata = rd_all[cfg_sel];

    bar_hit_decode #(
        .BAR_EN    (BAR_EN),
        .BAR_IO    (BAR_IO),
        .BAR_SIZE  (BAR_SIZE),
        .WIDE_MODE (WIDE_MODE),
        .ROM_EN    (ROM_EN),
        .ROM_SIZE  (ROM_SIZE)
    ) u_decode (
        .vals    (rd_val),
        .addr    (dec_addr),
        .is_io   (dec_io),
        .mem_en  (mem_en),
        .io_en   (io_en),
        .hit_vec (hit_vec)
    );

    assign hit_any = |hit_vec;

endmodule

// File: rtl/bar_bank_chk.sv
module bar_bank_chk
    import bar_bank_pkg::*;
#(
    parameter bit [NUM_BARS-1:0]       BAR_EN     = 6'b000001,
    parameter bit [NUM_BARS-1:0]       BAR_HW     = 6'b000000,
    parameter bit [NUM_BARS-1:0][31:0] BAR_HW_VAL = '0,
    parameter int                      WIDE_MODE  = 0
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cfg_wr,
    input logic [2:0]            cfg_sel,
    input logic                  mem_en,
    input logic                  io_en,
    input logic                  dec_io,
    input logic [6:0]            hit_vec,
    input word_t [NUM_SLOTS-1:0] rd_val
);

    // R11: at most one claimant is reported
    a_r11_single_hit: assert property (@(posedge clk) disable iff (rst) $onehot0(hit_vec));

    // R8: I/O transactions need the I/O-space enable
    a_r8_io_gate: assert property (@(posedge clk) disable iff (rst)
        (dec_io && !io_en) |-> (hit_vec == 7'h0));

    // R7: memory transactions need the memory-space enable
    a_r7_mem_gate: assert property (@(posedge clk) disable iff (rst)
        (!dec_io && !mem_en) |-> (hit_vec == 7'h0));

    // R9: ROM hit only with its enable bit set on a memory access
    a_r9_rom_gate: assert property (@(posedge clk) disable iff (rst)
        hit_vec[ROM_SLOT] |-> (rd_val[ROM_SLOT][0] && mem_en && !dec_io));

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_chk
        // R5: a slot not written this cycle keeps its value
        a_r5_untouched: assert property (@(posedge clk) disable iff (rst)
            !(cfg_wr && (cfg_sel == SEL_W'(k))) |=> $stable(rd_val[k]));

        if (k < NUM_BARS) begin : g_bar
            if (BAR_EN[k] && BAR_HW[k]) begin : g_hw
                // R4: hardwired slot shows its parameter word
                a_r4_hw_value: assert property (@(posedge clk) disable iff (rst)
                    rd_val[k] == BAR_HW_VAL[k]);
            end
            if (!((WIDE_MODE != 0) && (k == WIDE_MODE))) begin : g_attr
                // R3: attribute nibble never changes
                a_r3_attr_ro: assert property (@(posedge clk) disable iff (rst)
                    1'b1 |=> $stable(rd_val[k][3:0]));
            end
        end
    end

endmodule

bind bar_bank bar_bank_chk #(
    .BAR_EN     (BAR_EN),
    .BAR_HW     (BAR_HW),
    .BAR_HW_VAL (BAR_HW_VAL),
    .WIDE_MODE  (WIDE_MODE)
) chk_i (
    .clk     (clk),
    .rst     (rst),
    .cfg_wr  (cfg_wr),
    .cfg_sel (cfg_sel),
    .mem_en  (mem_en),
    .io_en   (io_en),
    .dec_io  (dec_io),
    .hit_vec (hit_vec),
    .rd_val  (rd_val)
);

// File: tb/bar_bank_tb_top.sv
module bar_bank_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata;
    logic        mem_en = 1'b0;
    logic        io_en = 1'b0;
    logic [63:0] dec_addr = 64'h0;
    logic        dec_io = 1'b0;
    logic [6:0]  hit_vec;
    logic        hit_any;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    // Slots 0-3 present; 2:1 form a prefetchable 64-bit pair; slot 3 hardwired I/O.
    bar_bank #(
        .BAR_EN     (6'b001111),
        .BAR_IO     (6'b001000),
        .BAR_PREF   (6'b000010),
        .BAR_SIZE   ({6'd12, 6'd12, 6'd8, 6'd12, 6'd16, 6'd20}),
        .BAR_HW     (6'b001000),
        .BAR_HW_VAL ({32'h0, 32'h0, 32'h0000_C005, 32'h0, 32'h0, 32'h0}),
        .WIDE_MODE  (2),
        .ROM_EN     (1'b1),
        .ROM_SIZE   (16)
    ) dut_i (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_be    (cfg_be),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .mem_en    (mem_en),
        .io_en     (io_en),
        .dec_addr  (dec_addr),
        .dec_io    (dec_io),
        .hit_vec   (hit_vec),
        .hit_any   (hit_any)
    );

    task automatic cfg_write(input logic [2:0] sel, input logic [3:0] be, input logic [31:0] data);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_be = be; cfg_wdata = data;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic check_read(input logic [2:0] sel, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_sel = sel;
        #1;
        checks++;
        if (cfg_rdata !== exp) begin
            errors++;
            $display("FAIL %s: read sel %0d got %h expected %h", req, sel, cfg_rdata, exp);
        end
    endtask

    task automatic probe_hit(input logic [63:0] a, input logic io, input logic [6:0] exp, input string req);
        dec_addr = a; dec_io = io;
        #1;
        checks++;
        if (hit_vec !== exp || hit_any !== (exp != 7'h0)) begin
            errors++;
            $display("FAIL %s: addr %h io %0d got hit %b/%b expected %b/%b",
                     req, a, io, hit_vec, hit_any, exp, exp != 7'h0);
        end
    endtask

    task automatic check_hit(input logic [63:0] a, input logic io, input logic [6:0] exp, input string req);
        @(negedge clk);
        probe_hit(a, io, exp, req);
    endtask

    task automatic t_reset_state;
        check_read(3'd0, 32'h0000_0000, "R1");
        check_read(3'd1, 32'h0000_000C, "R1");
        check_read(3'd2, 32'h0000_0000, "R1");
        check_read(3'd3, 32'h0000_C005, "R1");
        check_read(3'd6, 32'h0000_0000, "R1");
        check_read(3'd4, 32'h0000_0000, "R10");
        check_read(3'd7, 32'h0000_0000, "R10");
    endtask

    task automatic t_size_probe;
        cfg_write(3'd0, 4'hF, 32'hFFFF_FFFF);
        cfg_write(3'd1, 4'hF, 32'hFFFF_FFFF);
        cfg_write(3'd2, 4'hF, 32'hFFFF_FFFF);
        cfg_write(3'd6, 4'hF, 32'hFFFF_FFFF);
        cfg_write(3'd4, 4'hF, 32'hFFFF_FFFF);
        cfg_write(3'd7, 4'hF, 32'hFFFF_FFFF);
        check_read(3'd0, 32'hFFF0_0000, "R2");
        check_read(3'd1, 32'hFFFF_000C, "R2");
        check_read(3'd2, 32'hFFFF_FFFF, "R6");
        check_read(3'd6, 32'hFFFF_0001, "R9");
        check_read(3'd4, 32'h0000_0000, "R10");
        check_read(3'd7, 32'h0000_0000, "R10");
    endtask

    task automatic t_hardwired;
        cfg_write(3'd3, 4'hF, 32'h0000_0000);
        check_read(3'd3, 32'h0000_C005, "R4");
        cfg_write(3'd3, 4'hF, 32'hFFFF_FFFF);
        check_read(3'd3, 32'h0000_C005, "R4");
    endtask

    task automatic t_byte_lanes;
        cfg_write(3'd0, 4'hF, 32'h0000_0000);
        check_read(3'd0, 32'h0000_0000, "R5");
        cfg_write(3'd0, 4'b1000, 32'hABCD_EF00);
        check_read(3'd0, 32'hAB00_0000, "R5");
        cfg_write(3'd0, 4'b0100, 32'h0056_0000);
        check_read(3'd0, 32'hAB50_0000, "R5");
        cfg_write(3'd0, 4'b0000, 32'hFFFF_FFFF);
        check_read(3'd0, 32'hAB50_0000, "R5");
    endtask

    task automatic t_mem_decode;
        mem_en = 1'b1;
        cfg_write(3'd1, 4'hF, 32'h1234_0003);
        cfg_write(3'd2, 4'hF, 32'h0000_0001);
        check_read(3'd1, 32'h1234_000C, "R3");
        check_read(3'd2, 32'h0000_0001, "R6");
        check_hit(64'h0000_0000_AB5F_FFFC, 1'b0, 7'h01, "R7");
        check_hit(64'h0000_0000_AB60_0000, 1'b0, 7'h00, "R7");
        check_hit(64'h0000_0001_1234_ABCD, 1'b0, 7'h02, "R6");
        check_hit(64'h0000_0000_1234_ABCD, 1'b0, 7'h00, "R6");
        check_hit(64'h0000_0001_AB50_0000, 1'b0, 7'h00, "R6");
        mem_en = 1'b0;
        check_hit(64'h0000_0000_AB50_0010, 1'b0, 7'h00, "R7");
        mem_en = 1'b1;
    endtask

    task automatic t_io_decode;
        io_en = 1'b1;
        check_hit(64'h0000_0000_0000_C0FF, 1'b1, 7'h08, "R8");
        check_hit(64'h0000_0000_0000_C100, 1'b1, 7'h00, "R8");
        check_hit(64'h0000_0000_AB50_0010, 1'b1, 7'h00, "R8");
        check_hit(64'h0000_0000_0000_C010, 1'b0, 7'h00, "R7");
        io_en = 1'b0;
        check_hit(64'h0000_0000_0000_C010, 1'b1, 7'h00, "R8");
    endtask

    task automatic t_rom;
        cfg_write(3'd6, 4'hF, 32'h00AA_0000);
        check_read(3'd6, 32'h00AA_0000, "R9");
        check_hit(64'h0000_0000_00AA_1234, 1'b0, 7'h00, "R9");
        cfg_write(3'd6, 4'hF, 32'h00AA_07FF);
        check_read(3'd6, 32'h00AA_0001, "R9");
        check_hit(64'h0000_0000_00AA_1234, 1'b0, 7'h40, "R9");
        mem_en = 1'b0;
        check_hit(64'h0000_0000_00AA_1234, 1'b0, 7'h00, "R9");
        mem_en = 1'b1;
    endtask

    task automatic t_priority;
        cfg_write(3'd0, 4'hF, 32'h00A0_0000);
        check_hit(64'h0000_0000_00AA_1234, 1'b0, 7'h01, "R11");
        check_hit(64'h0000_0000_00A0_1234, 1'b0, 7'h01, "R11");
    endtask

    task automatic t_write_during_decode;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 3'd0; cfg_be = 4'hF; cfg_wdata = 32'h00B0_0000;
        probe_hit(64'h0000_0000_00A0_0010, 1'b0, 7'h01, "R12");
        @(negedge clk);
        cfg_wr = 1'b0;
        probe_hit(64'h0000_0000_00A0_0010, 1'b0, 7'h00, "R12");
        check_hit(64'h0000_0000_00B0_0010, 1'b0, 7'h01, "R12");
        check_hit(64'h0000_0000_00AA_1234, 1'b0, 7'h40, "R11");
    endtask

    task automatic t_rereset;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_read(3'd0, 32'h0000_0000, "R1");
        check_read(3'd1, 32'h0000_000C, "R1");
        check_read(3'd3, 32'h0000_C005, "R1");
        check_read(3'd6, 32'h0000_0000, "R1");
        check_hit(64'h0000_0000_00AA_1234, 1'b0, 7'h00, "R9");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_size_probe();
        t_hardwired();
        t_byte_lanes();
        t_mem_decode();
        t_io_decode();
        t_rom();
        t_priority();
        t_write_during_decode();
        t_rereset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule